// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous binary up-counter built from identical 4-bit stages. Each stage can be preset from a parallel data word and has two count enables. A stage advances only when both enables are high. Its terminal flag depends only on the second enable, the trail enable, and on the stage being full. The top module chains `STAGES` such stages. The trail enable of each stage comes from the terminal flag of the stage below it, so the whole chain behaves as one wide binary counter clocked by a single clock.

A build-time parameter, `ASYNC_CLR`, picks how the active-low clear acts. When it is 1 the clear acts at once, with no clock edge needed. When it is 0 the clear takes effect at the next rising edge. On each rising edge the stages apply a fixed priority: clear first, then parallel load, then count, then hold. The block has no data stream, so all of its pins are plain control and status signals with no valid/ready handshake.

Top module: `casc_counter`

## Requirements
- R1: Loads and increments take effect only on a rising clock edge. Input changes between edges leave `count` unchanged.
- R2: If `load_n` is low at a rising edge while `rst_n` is high, `count` takes `preset_data` on that edge, whatever the level of either enable.
- R3: A low `rst_n` drives `count` to zero whatever the levels of `load_n`, `cnt_en` and `trail_en`. When `ASYNC_CLR`=1 this happens immediately. When `ASYNC_CLR`=0 it happens at the next rising edge.
- R4: With `rst_n` and `load_n` high, `count` increases by one on a rising edge only when `cnt_en` and `trail_en` are both high. Otherwise it keeps its value.
- R5: `carry_out` is high exactly when `trail_en` is high and every bit of `count` is 1. `cnt_en` has no effect on it.
- R6: Counting from the all-ones value gives zero, and `carry_out` then goes low. No other flag marks the wrap.
- R7: A stage above the lowest one increments only on an edge where every lower stage holds 4'b1111 and both enables are high. Every stage is loaded on the same edge.
- R8: When `ASYNC_CLR`=1, a low `rst_n` forces `carry_out` low before any clock edge arrives.
- R9: In a 2-stage chain, loading 8'hFC and then counting gives 8'hFD, FE, FF, 00, 01, 02. The low stage therefore reads 12, 13, 14, 15, 0, 1, 2. When the enables then drop, the value holds at 8'h02.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all loads and increments happen on its rising edge |
| rst_n | input | 1 | Active-low clear; asynchronous or synchronous depending on `ASYNC_CLR` |
| load_n | input | 1 | Active-low parallel load strobe |
| cnt_en | input | 1 | Count enable, fed to every stage; does not affect the terminal flag |
| trail_en | input | 1 | Trail enable fed to the lowest stage; gates the terminal flag |
| preset_data | input | NIB_W*STAGES | Parallel preset value |
| count | output | NIB_W*STAGES | Current counter value |
| carry_out | output | 1 | Terminal flag of the top stage, used to cascade further |

## Verification
The checker tests these on every cycle: the edge rules for load, increment and hold, including wrapping at full width; that `carry_out` implies `trail_en` and a full count; and that `count` is zero after any edge sampled with clear low. It also checks the immediate clear in the asynchronous variant. Other behaviours need the bench's scenarios. These are the difference between the two clear variants within a single cycle, the sweep over every preset value against every load and enable combination, the R9 sequence with its hold, and the insensitivity to inputs changing between edges.

// File: rtl/casc_counter_pkg.sv
package casc_counter_pkg;

  typedef enum logic [1:0] {
    OP_CLEAR = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STEP  = 2'd2,
    OP_HOLD  = 2'd3
  } cnt_op_e;

  // Fixed priority: clear, then load, then step, otherwise hold.
  function automatic cnt_op_e pick_op(input logic rst_n, input logic load_n,
                                      input logic pe, input logic te);
    if (!rst_n)        return OP_CLEAR;
    else if (!load_n)  return OP_LOAD;
    else if (pe && te) return OP_STEP;
    else               return OP_HOLD;
  endfunction

endpackage

// File: rtl/casc_counter_next.sv
module casc_counter_next #(
  parameter int W = 4
) (
  input  casc_counter_pkg::cnt_op_e op,
  input  logic [W-1:0]              cur,
  input  logic [W-1:0]              din,
  output logic [W-1:0]              nxt
);
  import casc_counter_pkg::*;

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = din;
      OP_STEP:  nxt = cur + W'(1);
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/casc_counter_stage.sv
module casc_counter_stage #(
  parameter int W         = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_n,
  input  logic         pe,
  input  logic         te,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         tc
);
  import casc_counter_pkg::*;

  cnt_op_e      op;
  logic [W-1:0] q_nxt;

  assign op = pick_op(rst_n, load_n, pe, te);

  casc_counter_next #(.W(W)) u_next (
    .op  (op),
    .cur (q),
    .din (din),
    .nxt (q_nxt)
  );

  generate
    if (ASYNC_CLR) begin : g_aclr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_nxt;
      end
    end else begin : g_sclr
      // The clear is folded into q_nxt through OP_CLEAR.
      always_ff @(posedge clk) begin
        q <= q_nxt;
      end
    end
  endgenerate

  // Look-ahead flag: gated by te only, not by pe.
  assign tc = te & (&q);
endmodule

// File: rtl/casc_counter.sv
module casc_counter #(
  parameter int NIB_W     = 4,
  parameter int STAGES    = 2,
  parameter bit ASYNC_CLR = 1'b1,
  localparam int TOT_W    = NIB_W * STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic             cnt_en,
  input  logic             trail_en,
  input  logic [TOT_W-1:0] preset_data,
  output logic [TOT_W-1:0] count,
  output logic             carry_out
);
  logic [STAGES:0] te_chain;

  assign te_chain[0] = trail_en;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      casc_counter_stage #(.W(NIB_W), .ASYNC_CLR(ASYNC_CLR)) u_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_n (load_n),
        .pe     (cnt_en),
        .te     (te_chain[s]),
        .din    (preset_data[s*NIB_W +: NIB_W]),
        .q      (count[s*NIB_W +: NIB_W]),
        .tc     (te_chain[s+1])
      );
    end
  endgenerate

  assign carry_out = te_chain[STAGES];
endmodule

// File: rtl/casc_counter_chk.sv
module casc_counter_chk #(
  parameter int NIB_W     = 4,
  parameter int STAGES    = 2,
  parameter bit ASYNC_CLR = 1'b1,
  localparam int TOT_W    = NIB_W * STAGES
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_n,
  input logic             cnt_en,
  input logic             trail_en,
  input logic [TOT_W-1:0] preset_data,
  input logic [TOT_W-1:0] count,
  input logic             carry_out
);
  logic clr_seen_q;

  always_ff @(posedge clk) clr_seen_q <= !rst_n;

  // R2
  load_takes_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> count == $past(preset_data));

  // R4 R6 R7
  step_adds_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && cnt_en && trail_en) |=> count == $past(count) + TOT_W'(1));

  // R4
  hold_when_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !(cnt_en && trail_en)) |=> $stable(count));

  // R5
  carry_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out |-> (trail_en && (&count)));

  always @(negedge clk) begin
    // R3
    if (clr_seen_q === 1'b1)
      clear_zeroes_chk: assert (count == '0);
    // R8
    if (ASYNC_CLR && rst_n === 1'b0)
      async_clear_chk: assert (count == '0 && !carry_out);
  end
endmodule

bind casc_counter casc_counter_chk #(
  .NIB_W(NIB_W), .STAGES(STAGES), .ASYNC_CLR(ASYNC_CLR)
) u_chk (.*);

// File: tb/casc_counter_test.sv
module casc_counter_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n, load_n, cnt_en, trail_en;
  logic [W-1:0] preset_data;
  logic [W-1:0] cnt_a, cnt_s;
  logic carry_a, carry_s;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_cnt;

  always #10 clk = ~clk;

  casc_counter #(.NIB_W(4), .STAGES(2), .ASYNC_CLR(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .cnt_en(cnt_en),
    .trail_en(trail_en), .preset_data(preset_data),
    .count(cnt_a), .carry_out(carry_a));

  casc_counter #(.NIB_W(4), .STAGES(2), .ASYNC_CLR(1'b0)) uut_s (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .cnt_en(cnt_en),
    .trail_en(trail_en), .preset_data(preset_data),
    .count(cnt_s), .carry_out(carry_s));

  task automatic chk(input string req, input logic [W-1:0] act,
                     input logic [W-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic chk_both(input string req);
    chk(req, cnt_a, exp_cnt);
    chk(req, cnt_s, exp_cnt);
    chk("R5", W'(carry_a), W'(trail_en && exp_cnt == 8'hFF));
    chk("R5", W'(carry_s), W'(trail_en && exp_cnt == 8'hFF));
  endtask

  // Compute next value from the inputs held at the edge, pass the edge,
  // then compare. The mid-cycle check covers R1.
  task automatic tick(input string req);
    logic [W-1:0] nxt;
    @(negedge clk); #2;
    chk("R1", cnt_s, exp_cnt);
    if (!rst_n)                 nxt = '0;
    else if (!load_n)           nxt = preset_data;
    else if (cnt_en && trail_en) nxt = exp_cnt + 8'd1;
    else                        nxt = exp_cnt;
    @(posedge clk); #5;
    exp_cnt = nxt;
    chk_both(req);
  endtask

  task automatic drive(input logic r, input logic l, input logic e,
                       input logic t, input logic [W-1:0] d);
    rst_n = r; load_n = l; cnt_en = e; trail_en = t; preset_data = d;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    drive(1'b1, 1'b0, 1'b1, 1'b1, 8'hA5);
    #2 rst_n = 1'b0;
    #1;
    // R8 R3: async variant cleared without a clock edge
    chk("R8", cnt_a, 8'h00);
    chk("R8", W'(carry_a), 8'h00);
    exp_cnt = '0;
    // R3: clear wins over load and enables
    tick("R3");
    tick("R3");
    drive(1'b1, 1'b1, 1'b0, 1'b0, 8'h00);
    tick("R4");

    // R9: preset then count through the stage wrap, then inhibit
    drive(1'b1, 1'b0, 1'b0, 1'b0, 8'hFC);
    tick("R9");
    drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
    for (int i = 0; i < 6; i++) tick("R9");
    chk("R9", cnt_a, 8'h02);
    drive(1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
    tick("R9");
    tick("R9");
    chk("R9", cnt_a, 8'h02);

    // R5: flag ignores cnt_en
    drive(1'b1, 1'b0, 1'b0, 1'b1, 8'hFF);
    tick("R5");
    chk("R5", W'(carry_a), 8'h01);
    // R2: load held across what would be a wrap keeps reloading
    drive(1'b1, 1'b0, 1'b1, 1'b1, 8'hFF);
    tick("R2");
    tick("R2");
    // R6: wrap to zero, flag falls
    drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
    tick("R6");
    chk("R6", W'(carry_a), 8'h00);

    // R7: upper stage steps only when lower stage is full
    drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h3E);
    tick("R7");
    drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
    tick("R7");
    tick("R7");
    chk("R7", cnt_s, 8'h40);

    // Sweep: every preset value against every load/enable combination
    for (int v = 0; v < 256; v++) begin
      for (int c = 0; c < 8; c++) begin
        drive(1'b1, 1'b0, 1'b0, 1'b0, W'(v));
        tick("R2");
        drive(1'b1, c[0], c[1], c[2], ~W'(v));
        tick("R4");
      end
    end

    // R3 R8: mid-cycle clear, the two variants differ until the edge
    drive(1'b1, 1'b0, 1'b0, 1'b1, 8'hFF);
    tick("R2");
    rst_n = 1'b0;
    #1;
    chk("R8", cnt_a, 8'h00);
    chk("R8", W'(carry_a), 8'h00);
    chk("R3", cnt_s, 8'hFF);
    chk("R3", W'(carry_s), 8'h01);
    @(posedge clk); #5;
    exp_cnt = '0;
    chk_both("R3");
    drive(1'b1, 1'b1, 1'b1, 1'b1, 8'h00);
    tick("R4");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule